// File: doc/BRIEF.md
# Planar Adaptive Route Computation Unit

This unit computes the route for one input port of a wormhole router in a three-dimensional mesh. When a head flit arrives, it takes the current node's coordinates, the destination coordinates and the plane index carried with the packet. From these it produces a mask of the productive output ports the packet may use, the plane the packet now occupies, and the virtual channel class to request for that plane.

The dimensions are grouped into overlapping two-dimensional planes. Plane 0 covers X and Y, and plane 1 covers Y and Z. The packet visits the planes strictly in that order. Inside the active plane the packet may move in any productive direction of either dimension, so that choice is adaptive. A packet may leave a plane only after its offset in the plane's lower dimension is zero. Once a packet has moved on to a later plane, it never comes back to an earlier one.

The result is stored in a per-packet register when the head flit is accepted. It is held until the tail flit leaves the port.

Top module: `planar_route_unit`

## Requirements
- R1: After reset, `o_busy`, `o_route_valid`, `o_port_mask`, `o_plane` and `o_vc` are all zero.
- R2: When `i_head_valid` is high and `o_busy` is low at a rising edge, the head is accepted. After that same edge, `o_route_valid` is high for exactly one cycle, and `o_busy` is high.
- R3: Only the two dimensions of the active plane can set port bits. Plane p covers dimension p and dimension p+1, where dimension 0 is X, 1 is Y and 2 is Z.
- R4: Each dimension d has two port bits. Bit 2d is the plus direction and is set when the destination coordinate is greater than the current one. Bit 2d+1 is the minus direction and is set when the destination coordinate is smaller. When the two coordinates are equal, neither bit is set. Coordinates are unsigned 4-bit fields, with dimension d at bits [4d+3:4d].
- R5: If the offset in the lower dimension of the incoming plane is zero, the reported plane advances by one in the same cycle, and this can repeat across several planes. The port mask is then taken from the advanced plane.
- R6: The reported plane is never lower than the incoming plane. A dimension that lies below the active plane never sets a port bit.
- R7: When every offset is zero, only the local ejection bit (bit 2*NDIM, which is bit 6) is set. The plane is still reported as described in R5.
- R8: `o_vc` equals `o_plane` multiplied by `VC_PER_PLANE`. This gives each plane its own virtual channel class.
- R9: While `o_busy` is high, the mask, plane and VC outputs hold their values. A pulse on `i_tail_done` while busy clears all outputs to zero.
- R10: A head flit presented while `o_busy` is high is ignored. This includes a head that arrives together with the tail. No valid pulse is produced and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_head_valid | input | 1 | A head flit is present with its coordinates |
| i_tail_done | input | 1 | The tail flit of the current packet has left the port |
| i_cur | input | NDIM*CW | Coordinates of the current node |
| i_dst | input | NDIM*CW | Coordinates of the destination node |
| i_plane_in | input | PW | Plane index carried with the packet |
| o_busy | output | 1 | A packet holds this route |
| o_route_valid | output | 1 | One-cycle pulse when a new route is ready |
| o_port_mask | output | 2*NDIM+1 | Allowed output ports |
| o_plane | output | PW | Active plane of the packet |
| o_vc | output | VCW | Base index of the virtual channel class to request |

## Verification
The bench builds the unit with its default parameters: three dimensions, 4-bit coordinates and two virtual channels per plane. With these values there are two planes and seven port bits. This makes the coordinate extremes 0 and 15 reachable, as well as the case where a plane advances while the packet is still in the X-Y plane. It also exercises a packet arriving already in the Y-Z plane with an X offset that must stay unused, and ejection in both planes. On the control side it covers a head that arrives while a packet is still active, and a head that coincides with the tail.

// File: rtl/planar_route_pkg.sv
package planar_route_pkg;

    typedef enum logic [1:0] {
        STEP_NONE  = 2'b00,
        STEP_PLUS  = 2'b01,
        STEP_MINUS = 2'b10
    } step_e;

    localparam int MAX_CW = 16;

    // Direction of travel along one dimension from the sign of (dst - cur).
    function automatic step_e step_of(input logic [MAX_CW-1:0] cur,
                                      input logic [MAX_CW-1:0] dst);
        if (dst > cur)      return STEP_PLUS;
        else if (dst < cur) return STEP_MINUS;
        else                return STEP_NONE;
    endfunction

    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rt_dim_step.sv
module rt_dim_step
    import planar_route_pkg::*;
#(
    parameter int NDIM = 3,
    parameter int CW   = 4
) (
    input  logic [NDIM*CW-1:0] i_cur,
    input  logic [NDIM*CW-1:0] i_dst,
    output logic [NDIM-1:0]    o_plus,
    output logic [NDIM-1:0]    o_minus,
    output logic [NDIM-1:0]    o_zero
);
    for (genvar d = 0; d < NDIM; d++) begin : g_dim
        step_e st;
        assign st = step_of(MAX_CW'(i_cur[d*CW +: CW]), MAX_CW'(i_dst[d*CW +: CW]));
        assign o_plus[d]  = (st == STEP_PLUS);
        assign o_minus[d] = (st == STEP_MINUS);
        assign o_zero[d]  = (st == STEP_NONE);
    end
endmodule

// File: rtl/rt_plane_pick.sv
module rt_plane_pick #(
    parameter int NDIM = 3,
    parameter int PW   = 1
) (
    input  logic [PW-1:0]   i_plane_in,
    input  logic [NDIM-1:0] i_zero,
    output logic [PW-1:0]   o_plane
);
    localparam int NPLANE = NDIM - 1;
    localparam logic [PW-1:0] LAST = PW'(NPLANE - 1);

    always_comb begin
        logic [PW-1:0] eff;
        eff = (i_plane_in > LAST) ? LAST : i_plane_in;
        // Exit rule: leave plane p once its lowest dimension p is resolved.
        for (int p = 0; p < NPLANE - 1; p++) begin
            if (eff == PW'(p) && i_zero[p]) eff = PW'(p + 1);
        end
        o_plane = eff;
    end
endmodule

// File: rtl/rt_port_mask.sv
module rt_port_mask #(
    parameter int NDIM = 3,
    parameter int PW   = 1
) (
    input  logic [PW-1:0]     i_plane,
    input  logic [NDIM-1:0]   i_plus,
    input  logic [NDIM-1:0]   i_minus,
    input  logic [NDIM-1:0]   i_zero,
    output logic [2*NDIM:0]   o_mask
);
    always_comb begin
        o_mask = '0;
        for (int d = 0; d < NDIM; d++) begin
            if (d == int'(i_plane) || d == int'(i_plane) + 1) begin
                o_mask[2*d]     = i_plus[d];
                o_mask[2*d + 1] = i_minus[d];
            end
        end
        o_mask[2*NDIM] = &i_zero;
    end
endmodule

// File: rtl/planar_route_unit.sv
module planar_route_unit
    import planar_route_pkg::*;
#(
    parameter int NDIM         = 3,
    parameter int CW           = 4,
    parameter int VC_PER_PLANE = 2,
    localparam int NPLANE      = NDIM - 1,
    localparam int PW          = width_of(NPLANE),
    localparam int VCW         = width_of(NPLANE * VC_PER_PLANE),
    localparam int NPORT       = 2 * NDIM + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               i_head_valid,
    input  logic               i_tail_done,
    input  logic [NDIM*CW-1:0] i_cur,
    input  logic [NDIM*CW-1:0] i_dst,
    input  logic [PW-1:0]      i_plane_in,
    output logic               o_busy,
    output logic               o_route_valid,
    output logic [NPORT-1:0]   o_port_mask,
    output logic [PW-1:0]      o_plane,
    output logic [VCW-1:0]     o_vc
);
    logic [NDIM-1:0]  plus, minus, zero;
    logic [PW-1:0]    eff_plane;
    logic [NPORT-1:0] mask_next;
    logic             accept;

    rt_dim_step #(.NDIM(NDIM), .CW(CW)) i_step (
        .i_cur(i_cur), .i_dst(i_dst),
        .o_plus(plus), .o_minus(minus), .o_zero(zero)
    );

    rt_plane_pick #(.NDIM(NDIM), .PW(PW)) i_pick (
        .i_plane_in(i_plane_in), .i_zero(zero), .o_plane(eff_plane)
    );

    rt_port_mask #(.NDIM(NDIM), .PW(PW)) i_mask (
        .i_plane(eff_plane), .i_plus(plus), .i_minus(minus),
        .i_zero(zero), .o_mask(mask_next)
    );

    assign accept = i_head_valid && !o_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            o_busy        <= 1'b0;
            o_route_valid <= 1'b0;
            o_port_mask   <= '0;
            o_plane       <= '0;
            o_vc          <= '0;
        end else begin
            o_route_valid <= accept;
            if (o_busy && i_tail_done) begin
                o_busy      <= 1'b0;
                o_port_mask <= '0;
                o_plane     <= '0;
                o_vc        <= '0;
            end else if (accept) begin
                o_busy      <= 1'b1;
                o_port_mask <= mask_next;
                o_plane     <= eff_plane;
                o_vc        <= VCW'(eff_plane) * VCW'(VC_PER_PLANE);
            end
        end
    end
endmodule

// File: rtl/planar_route_checks.sv
module planar_route_checks #(
    parameter int NDIM         = 3,
    parameter int CW           = 4,
    parameter int VC_PER_PLANE = 2,
    parameter int PW           = 1,
    parameter int VCW          = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               i_head_valid,
    input logic               i_tail_done,
    input logic [PW-1:0]      i_plane_in,
    input logic               o_busy,
    input logic               o_route_valid,
    input logic [2*NDIM:0]    o_port_mask,
    input logic [PW-1:0]      o_plane,
    input logic [VCW-1:0]     o_vc
);
    a_r2_valid_after_head: assert property (@(posedge clk) disable iff (rst)
        (i_head_valid && !o_busy) |=> (o_route_valid && o_busy));

    a_r2_valid_single: assert property (@(posedge clk) disable iff (rst)
        o_route_valid |=> !o_route_valid);

    a_r6_no_return: assert property (@(posedge clk) disable iff (rst)
        o_route_valid |-> (o_plane >= $past(i_plane_in)));

    a_r7_local_alone: assert property (@(posedge clk) disable iff (rst)
        o_port_mask[2*NDIM] |-> ($countones(o_port_mask) == 1));

    a_r8_vc_class: assert property (@(posedge clk) disable iff (rst)
        o_busy |-> (int'(o_vc) == int'(o_plane) * VC_PER_PLANE));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (o_busy && !i_tail_done) |=> ($stable(o_port_mask) && $stable(o_plane) && $stable(o_vc)));

    a_r9_tail_clears: assert property (@(posedge clk) disable iff (rst)
        (o_busy && i_tail_done) |=> (!o_busy && o_port_mask == '0 && o_plane == '0));

    a_r10_busy_head_ignored: assert property (@(posedge clk) disable iff (rst)
        (o_busy && i_head_valid) |=> !o_route_valid);
endmodule

bind planar_route_unit planar_route_checks #(
    .NDIM(NDIM), .CW(CW), .VC_PER_PLANE(VC_PER_PLANE), .PW(PW), .VCW(VCW)
) i_checks (
    .clk(clk), .rst(rst), .i_head_valid(i_head_valid), .i_tail_done(i_tail_done),
    .i_plane_in(i_plane_in), .o_busy(o_busy), .o_route_valid(o_route_valid),
    .o_port_mask(o_port_mask), .o_plane(o_plane), .o_vc(o_vc)
);

// File: tb/test_planar_route_unit.sv
module test_planar_route_unit;
    localparam int NDIM = 3;
    localparam int CW   = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        i_head_valid, i_tail_done;
    logic [11:0] i_cur, i_dst;
    logic [0:0]  i_plane_in;
    logic        o_busy, o_route_valid;
    logic [6:0]  o_port_mask;
    logic [0:0]  o_plane;
    logic [1:0]  o_vc;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    planar_route_unit #(.NDIM(NDIM), .CW(CW), .VC_PER_PLANE(2)) i_planar_route_unit (
        .clk(clk), .rst(rst), .i_head_valid(i_head_valid), .i_tail_done(i_tail_done),
        .i_cur(i_cur), .i_dst(i_dst), .i_plane_in(i_plane_in),
        .o_busy(o_busy), .o_route_valid(o_route_valid), .o_port_mask(o_port_mask),
        .o_plane(o_plane), .o_vc(o_vc)
    );

    function automatic logic [11:0] xyz(input int x, input int y, input int z);
        return {4'(z), 4'(y), 4'(x)};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Presents a head at a negedge; returns one negedge after the capturing edge.
    task automatic send_head(input logic [11:0] c, input logic [11:0] d, input int pl);
        @(negedge clk);
        i_cur = c; i_dst = d; i_plane_in = 1'(pl); i_head_valid = 1'b1;
        @(negedge clk);
        i_head_valid = 1'b0;
    endtask

    task automatic send_tail();
        @(negedge clk);
        i_tail_done = 1'b1;
        @(negedge clk);
        i_tail_done = 1'b0;
        chk("R9 busy cleared", int'(o_busy), 0);
        chk("R9 mask cleared", int'(o_port_mask), 0);
        chk("R9 plane cleared", int'(o_plane), 0);
    endtask

    task automatic route_case(input string tag, input logic [11:0] c, input logic [11:0] d,
                              input int pl, input int exp_mask, input int exp_plane);
        send_head(c, d, pl);
        chk({tag, " R2 valid"}, int'(o_route_valid), 1);
        chk({tag, " R2 busy"}, int'(o_busy), 1);
        chk({tag, " mask"}, int'(o_port_mask), exp_mask);
        chk({tag, " plane"}, int'(o_plane), exp_plane);
        chk({tag, " R8 vc"}, int'(o_vc), exp_plane * 2);
        @(negedge clk);
        chk({tag, " R2 valid single"}, int'(o_route_valid), 0);
        chk({tag, " R9 held mask"}, int'(o_port_mask), exp_mask);
        send_tail();
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(o_busy), 0);
        chk("R1 valid", int'(o_route_valid), 0);
        chk("R1 mask", int'(o_port_mask), 0);
        chk("R1 plane", int'(o_plane), 0);
        chk("R1 vc", int'(o_vc), 0);
    endtask

    // R3 R4: X-Y plane, X+ (bit0) and Y- (bit3), Z offset ignored.
    task automatic t_xy_plane();
        route_case("R3 R4 xy", xyz(2,5,7), xyz(9,1,3), 0, 7'h09, 0);
    endtask

    // R5: X resolved, advance to Y-Z; Y+ (bit2), Z- (bit5).
    task automatic t_advance();
        route_case("R5 advance", xyz(4,4,4), xyz(4,8,1), 0, 7'h24, 1);
    endtask

    // R6: already in Y-Z with X offset; only Z+ (bit4).
    task automatic t_no_return();
        route_case("R6 no return", xyz(0,3,3), xyz(5,3,9), 1, 7'h10, 1);
    endtask

    // R7: arrival in both planes selects local port.
    task automatic t_local();
        route_case("R7 local p1", xyz(6,6,6), xyz(6,6,6), 1, 7'h40, 1);
        route_case("R7 local p0", xyz(0,0,0), xyz(0,0,0), 0, 7'h40, 1);
    endtask

    // R4: coordinate extremes, X- (bit1), Y+ (bit2).
    task automatic t_extremes();
        route_case("R4 extremes", xyz(15,0,8), xyz(0,15,2), 0, 7'h06, 0);
    endtask

    // R10: head while busy, and head together with tail.
    task automatic t_busy_head();
        send_head(xyz(1,1,1), xyz(3,1,1), 0);
        chk("R10 setup mask", int'(o_port_mask), 7'h01);
        send_head(xyz(9,9,9), xyz(2,2,2), 1);
        chk("R10 no valid", int'(o_route_valid), 0);
        chk("R10 mask unchanged", int'(o_port_mask), 7'h01);
        chk("R10 plane unchanged", int'(o_plane), 0);
        @(negedge clk);
        i_cur = xyz(9,9,9); i_dst = xyz(2,2,2); i_plane_in = 1'b1;
        i_head_valid = 1'b1; i_tail_done = 1'b1;
        @(negedge clk);
        i_head_valid = 1'b0; i_tail_done = 1'b0;
        chk("R10 tail wins busy", int'(o_busy), 0);
        chk("R10 tail wins valid", int'(o_route_valid), 0);
        chk("R10 tail wins mask", int'(o_port_mask), 0);
    endtask

    initial begin
        rst = 1'b1; i_head_valid = 1'b0; i_tail_done = 1'b0;
        i_cur = '0; i_dst = '0; i_plane_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_xy_plane();
        t_advance();
        t_no_return();
        t_local();
        t_extremes();
        t_busy_head();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule